// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block sequences the recording of a probe word into an internal sample buffer whose depth is a parameter. The host first selects a capture mode and a pre-trigger sample count and then issues a start command. In single-shot mode the controller first records the requested number of history samples. It then keeps overwriting the buffer circularly until the trigger input is seen, and after that it keeps recording until the buffer is full.

In qualified mode the controller writes a sample only on cycles where the trigger input is high. In free-running mode it records every cycle straight away and pays no attention to the trigger. When the controller finishes, it reports the buffer index that holds the oldest sample. The host then reads the buffer through a registered read port, starting at that index and wrapping modulo the depth, and gets the samples in time order.

The pre-trigger count resets to half the depth. A host reset command aborts any capture.

Top module: `la_capture_ctrl`

## Requirements
- R1: After the asynchronous reset the status state is idle (0), the mode is single-shot (0), the pre-trigger count is DEPTH/2 and the start index is 0. State codes are: 0 idle, 1 history fill, 2 armed, 3 recording, 4 done.
- R2: A pre-trigger count written while idle is stored as written when it is below DEPTH, and is stored as DEPTH-1 otherwise. A write made outside idle leaves the stored count unchanged.
- R3: A mode write made while idle stores 0 (single-shot), 1 (qualified) or 2 (free-running). A write of code 3 is ignored, and so is any mode write made outside idle.
- R4: In single-shot mode a start moves the controller to history fill, or straight to armed when the count is 0. The trigger has no effect during history fill, and the controller becomes armed after it has recorded exactly count samples.
- R5: In single-shot mode the controller stays armed until a trigger cycle, while recording every cycle and wrapping. When capture completes, the DEPTH entries read from the start index onward hold count samples from before the trigger cycle, then the sample from the trigger cycle, then the samples that followed, with one sample per cycle.
- R6: In single-shot mode the reported start index equals the write position of the trigger sample minus the count, modulo DEPTH.
- R7: In qualified mode a start goes directly to recording. A sample is written only on cycles with the trigger high, the start index is 0, and the state becomes done once DEPTH such samples are stored.
- R8: In free-running mode a start goes directly to recording. DEPTH consecutive samples are stored at addresses 0 upward, beginning with the cycle after the start, and the state becomes done right after the last one.
- R9: A host reset command returns the controller to idle from any state on the next cycle, clears the write position and the start index, and overrides a start command given in the same cycle.
- R10: Outside recording, rd_data shows the buffer word at rd_addr one clock cycle after the address is presented.
- R11: In the done state the controller ignores start commands and trigger activity. The state, the start index and the buffer contents stay as they are until a host reset command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Host start command, one-cycle pulse |
| cmd_reset | input | 1 | Host abort command, returns the controller to idle |
| cfg_mode_we | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode value: 0 single-shot, 1 qualified, 2 free-running |
| cfg_loc_we | input | 1 | Pre-trigger count write strobe |
| cfg_loc | input | $clog2(DEPTH)+1 | Pre-trigger count value, clamped to DEPTH-1 |
| trig_in | input | 1 | Trigger condition from the external evaluator |
| probe_in | input | WIDTH | Probe word to be sampled |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | WIDTH | Registered buffer read data |
| stat_state | output | 3 | Controller state code |
| stat_start_idx | output | $clog2(DEPTH) | Buffer index of the oldest captured sample |
| cfg_mode_q | output | 2 | Stored mode |
| cfg_loc_q | output | $clog2(DEPTH) | Stored pre-trigger count |

## Verification
The assertions rely on a few things the host is expected to do. It changes the mode and the pre-trigger count only while the controller is idle. It keeps command pulses one cycle long. It reads the buffer only after recording has stopped, because the single port gives all its cycles to writes while recording. The stimulus drives every input on the falling clock edge and polls the status state before triggering, so each trigger lands in a known write position. The configuration writes that are made outside idle, or that use code 3, are deliberate probes, and the bench checks them by reading back the stored values.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FILL   = 3'd1,
    ST_ARMED  = 3'd2,
    ST_RECORD = 3'd3,
    ST_DONE   = 3'd4
  } cap_state_e;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_QUAL   = 2'd1,
    MD_FREE   = 2'd2
  } cap_mode_e;
endpackage

// File: rtl/la_cap_cfg.sv
module la_cap_cfg
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          mode_we,
  input  logic [1:0]    mode_in,
  input  logic          loc_we,
  input  logic [LW-1:0] loc_in,
  output cap_mode_e     mode_q,
  output logic [AW-1:0] loc_q
);
  localparam logic [AW-1:0] LOC_RST = AW'(DEPTH / 2);
  localparam logic [AW-1:0] LOC_MAX = AW'(DEPTH - 1);

  logic [AW-1:0] loc_clamped;
  logic          mode_en;
  logic          loc_en;

  always_comb begin
    loc_clamped = (loc_in >= LW'(DEPTH)) ? LOC_MAX : loc_in[AW-1:0];
    mode_en     = idle && mode_we && (mode_in != 2'd3);
    loc_en      = idle && loc_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_SINGLE;
    end else if (mode_en) begin
      mode_q <= cap_mode_e'(mode_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q <= LOC_RST;
    end else if (loc_en) begin
      loc_q <= loc_clamped;
    end
  end
endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          cmd_reset,
  input  logic          trig,
  input  cap_mode_e     mode,
  input  logic [AW-1:0] loc,
  output cap_state_e    state,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] start_idx,
  output logic          wr_en
);
  localparam logic [AW-1:0] ONE = AW'(1);

  cap_state_e    state_n;
  logic [AW-1:0] wptr_n;
  logic [AW-1:0] start_n;
  logic [AW-1:0] wptr_inc;
  logic [AW-1:0] trig_start;

  always_comb begin
    wptr_inc   = wptr + ONE;
    trig_start = wptr - loc;
    state_n    = state;
    wptr_n     = wptr;
    start_n    = start_idx;
    wr_en      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmd_start) begin
          wptr_n  = '0;
          start_n = '0;
          if (mode == MD_SINGLE) begin
            state_n = (loc == '0) ? ST_ARMED : ST_FILL;
          end else begin
            state_n = ST_RECORD;
          end
        end
      end
      ST_FILL: begin
        wr_en  = 1'b1;
        wptr_n = wptr_inc;
        if (wptr_inc == loc) begin
          state_n = ST_ARMED;
        end
      end
      ST_ARMED: begin
        wr_en  = 1'b1;
        wptr_n = wptr_inc;
        if (trig) begin
          start_n = trig_start;
          state_n = (wptr_inc == trig_start) ? ST_DONE : ST_RECORD;
        end
      end
      ST_RECORD: begin
        wr_en = (mode == MD_QUAL) ? trig : 1'b1;
        if (wr_en) begin
          wptr_n = wptr_inc;
          if (wptr_inc == start_idx) begin
            state_n = ST_DONE;
          end
        end
      end
      default: begin
      end
    endcase
    if (cmd_reset) begin
      state_n = ST_IDLE;
      wptr_n  = '0;
      start_n = '0;
      wr_en   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wptr      <= '0;
      start_idx <= '0;
    end else begin
      state     <= state_n;
      wptr      <= wptr_n;
      start_idx <= start_n;
    end
  end
endmodule

// File: rtl/la_cap_mem.sv
module la_cap_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [AW-1:0]    raddr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    port_addr;
  logic             rd_en;

  always_comb begin
    port_addr = we ? waddr : raddr;
    rd_en     = !we;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      store[port_addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= store[port_addr];
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_reset,
  input  logic             cfg_mode_we,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_loc_we,
  input  logic [LW-1:0]    cfg_loc,
  input  logic             trig_in,
  input  logic [WIDTH-1:0] probe_in,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [2:0]       stat_state,
  output logic [AW-1:0]    stat_start_idx,
  output logic [1:0]       cfg_mode_q,
  output logic [AW-1:0]    cfg_loc_q
);
  cap_state_e    state;
  cap_mode_e     mode_q;
  logic [AW-1:0] loc_q;
  logic [AW-1:0] wptr;
  logic [AW-1:0] start_idx;
  logic          wr_en;
  logic          is_idle;

  assign is_idle = (state == ST_IDLE);

  la_cap_cfg #(.DEPTH(DEPTH)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (is_idle),
    .mode_we (cfg_mode_we),
    .mode_in (cfg_mode),
    .loc_we  (cfg_loc_we),
    .loc_in  (cfg_loc),
    .mode_q  (mode_q),
    .loc_q   (loc_q)
  );

  la_cap_fsm #(.DEPTH(DEPTH)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_reset (cmd_reset),
    .trig      (trig_in),
    .mode      (mode_q),
    .loc       (loc_q),
    .state     (state),
    .wptr      (wptr),
    .start_idx (start_idx),
    .wr_en     (wr_en)
  );

  la_cap_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) mem_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wptr),
    .raddr (rd_addr),
    .wdata (probe_in),
    .rdata (rd_data)
  );

  assign stat_state     = state;
  assign stat_start_idx = start_idx;
  assign cfg_mode_q     = mode_q;
  assign cfg_loc_q      = loc_q;
endmodule

// File: rtl/la_cap_chk.sv
module la_cap_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          cmd_reset,
  input logic [2:0]    state,
  input logic [1:0]    mode_q,
  input logic [AW-1:0] loc_q,
  input logic [AW-1:0] start_idx
);
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4);

  a_r2_loc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0) |=> $stable(loc_q));

  a_r3_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0) |=> $stable(mode_q));

  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3);

  a_r4_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && cmd_start && !cmd_reset && mode_q == 2'd0 && loc_q != '0)
      |=> state == 3'd1);

  a_r8_free_record: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && cmd_start && !cmd_reset && mode_q == 2'd2)
      |=> state == 3'd3);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (state == 3'd0 && start_idx == '0));

  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !cmd_reset) |=> (state == 3'd4 && $stable(start_idx)));
endmodule

bind la_capture_ctrl la_cap_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_reset (cmd_reset),
  .state     (stat_state),
  .mode_q    (cfg_mode_q),
  .loc_q     (cfg_loc_q),
  .start_idx (stat_start_idx)
);

// File: tb/la_capture_ctrl_tb_top.sv
module la_capture_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int W  = 8;
  localparam int AW = $clog2(D);
  localparam int LW = AW + 1;
  localparam int NVEC = 5;
  // each row: pre-trigger count written, armed cycles before trigger, stored count
  localparam int VEC [NVEC][3] = '{
    '{4, 0, 4}, '{0, 2, 0}, '{15, 5, 15}, '{20, 1, 15}, '{16, 7, 15}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_reset = 1'b0;
  logic cfg_mode_we = 1'b0, cfg_loc_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [LW-1:0] cfg_loc = '0;
  logic trig_in = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [2:0] stat_state;
  logic [AW-1:0] stat_start_idx;
  logic [1:0] cfg_mode_q;
  logic [AW-1:0] cfg_loc_q;
  int tick = 0;
  int checks = 0, errors = 0;
  int got [D];
  int expv [D];
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  la_capture_ctrl #(.DEPTH(D), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_reset(cmd_reset),
    .cfg_mode_we(cfg_mode_we), .cfg_mode(cfg_mode), .cfg_loc_we(cfg_loc_we),
    .cfg_loc(cfg_loc), .trig_in(trig_in), .probe_in(tick[W-1:0]),
    .rd_addr(rd_addr), .rd_data(rd_data), .stat_state(stat_state),
    .stat_start_idx(stat_start_idx), .cfg_mode_q(cfg_mode_q), .cfg_loc_q(cfg_loc_q)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic pulse(input bit st, input bit rs, output int t);
    @(negedge clk);
    cmd_start = st; cmd_reset = rs; t = tick;
    @(negedge clk);
    cmd_start = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic abort();
    int t;
    pulse(1'b0, 1'b1, t);
  endtask

  task automatic set_loc(input int v);
    @(negedge clk); cfg_loc_we = 1'b1; cfg_loc = LW'(v);
    @(negedge clk); cfg_loc_we = 1'b0;
  endtask

  task automatic set_mode(input int v);
    @(negedge clk); cfg_mode_we = 1'b1; cfg_mode = 2'(v);
    @(negedge clk); cfg_mode_we = 1'b0;
  endtask

  task automatic wait_state(input int s);
    int n = 0;
    while (stat_state != 3'(s) && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic read_buf(input int base);
    for (int k = 0; k < D; k++) begin
      rd_addr = AW'((base + k) % D);
      @(negedge clk);
      got[k] = rd_data;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t, tv, n, i, ok;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 state", stat_state, 0);
    chk("R1 mode", cfg_mode_q, 0);
    chk("R1 loc", cfg_loc_q, D / 2);
    chk("R1 start", stat_start_idx, 0);

    // R3 code 3 ignored
    set_mode(1); set_mode(3);
    chk("R3 code3 ignored", cfg_mode_q, 1);
    set_mode(0);
    chk("R3 single stored", cfg_mode_q, 0);

    // vector table: single-shot captures with varied count and trigger delay
    for (int v = 0; v < NVEC; v++) begin
      set_loc(VEC[v][0]);
      chk("R2 loc clamp", cfg_loc_q, VEC[v][2]);
      pulse(1'b1, 1'b0, t);
      chk("R4 start state", stat_state, (VEC[v][2] == 0) ? 2 : 1);
      wait_state(2);
      repeat (VEC[v][1]) @(negedge clk);
      chk("R5 still armed", stat_state, 2);
      trig_in = 1'b1; tv = tick;
      @(negedge clk); trig_in = 1'b0;
      wait_state(4);
      chk("R5 done", stat_state, 4);
      chk("R6 start idx", stat_start_idx, VEC[v][1] % D);
      read_buf(stat_start_idx);
      ok = 1;
      for (int k = 0; k < D; k++)
        if (got[k] != ((tv - VEC[v][2] + k) & 255)) ok = 0;
      chk("R5 time order", ok, 1);
      chk("R10 trigger word", got[VEC[v][2]], tv & 255);
      abort();
      chk("R9 idle", stat_state, 0);
    end

    // R4 trigger held during history fill is ignored
    set_loc(4);
    trig_in = 1'b1;
    pulse(1'b1, 1'b0, t);
    wait_state(2);
    tv = tick;
    @(negedge clk); trig_in = 1'b0;
    wait_state(4);
    chk("R4 fill trig ignored idx", stat_start_idx, 0);
    read_buf(0);
    chk("R4 trigger word", got[4], tv & 255);
    chk("R4 oldest word", got[0], (tv - 4) & 255);

    // R11 done holds against start and trigger
    trig_in = 1'b1;
    pulse(1'b1, 1'b0, t);
    trig_in = 1'b0;
    chk("R11 done held", stat_state, 4);
    read_buf(0);
    chk("R11 buffer kept", got[4], tv & 255);
    abort();

    // R2 R3 writes outside idle ignored
    set_loc(6);
    pulse(1'b1, 1'b0, t);
    chk("R2 in fill", stat_state, 1);
    @(negedge clk);
    cfg_loc_we = 1'b1; cfg_loc = LW'(2); cfg_mode_we = 1'b1; cfg_mode = 2'd2;
    @(negedge clk);
    cfg_loc_we = 1'b0; cfg_mode_we = 1'b0;
    chk("R2 loc locked", cfg_loc_q, 6);
    chk("R3 mode locked", cfg_mode_q, 0);
    abort();
    chk("R9 abort from fill", stat_state, 0);

    // R8 free-running capture
    set_mode(2);
    trig_in = 1'b0;
    pulse(1'b1, 1'b0, t);
    chk("R8 recording", stat_state, 3);
    repeat (D - 1) @(negedge clk);
    chk("R8 not yet done", stat_state, 3);
    @(negedge clk);
    chk("R8 done", stat_state, 4);
    chk("R8 start idx", stat_start_idx, 0);
    read_buf(0);
    ok = 1;
    for (int k = 0; k < D; k++) if (got[k] != ((t + 1 + k) & 255)) ok = 0;
    chk("R8 samples", ok, 1);
    abort();

    // R7 qualified capture
    set_mode(1);
    pulse(1'b1, 1'b0, t);
    chk("R7 recording", stat_state, 3);
    n = 0; i = 0;
    while (n < D) begin
      trig_in = ((i % 3) != 0);
      if (trig_in) begin expv[n] = tick & 255; n++; end
      i++;
      @(negedge clk);
      if (n == D - 1) chk("R7 not early", stat_state, 3);
    end
    trig_in = 1'b0;
    chk("R7 done", stat_state, 4);
    chk("R7 start idx", stat_start_idx, 0);
    read_buf(0);
    ok = 1;
    for (int k = 0; k < D; k++) if (got[k] != expv[k]) ok = 0;
    chk("R7 qualified samples", ok, 1);
    abort();

    // R9 abort mid-record and abort beats start
    set_mode(2);
    pulse(1'b1, 1'b0, t);
    repeat (3) @(negedge clk);
    abort();
    chk("R9 abort from record", stat_state, 0);
    chk("R9 start cleared", stat_start_idx, 0);
    pulse(1'b1, 1'b1, t);
    chk("R9 reset beats start", stat_state, 0);

    finish_run();
  end
endmodule